// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and access strobes into a status word, a set of interrupt sources, one combined interrupt line and a pair of DMA request lines. It does not store FIFO data and does not run the serial engine. It watches the levels, the push and pop strobes, the "frame delivered" strobe from the engine and the engine's busy flag.

Two sources are level-type. They follow the FIFO levels against programmable thresholds. Three sources are error events (transmit overflow, receive underflow, receive overflow). These latch and stay set until software clears them. Clears go through a write-to-clear register whose bit order differs from the interrupt vector. A mask register gates the raw vector into the masked vector. A two-bit DMA enable register gates the threshold conditions onto the DMA request lines. The bus decoder outside the block supplies the register writes as simple write strobes with data.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: The status word is combinational from the inputs: bit 0 busy, bit 1 transmit level equals DEPTH, bit 2 transmit level is zero, bit 3 receive level is zero, bit 4 receive level equals DEPTH.
- R2: The raw vector layout is bit 0 tx-low, bit 1 tx-overflow, bit 2 rx-underflow, bit 3 rx-overflow, bit 4 rx-high. After reset the mask, the DMA enables and both thresholds are zero, and the sticky bits are clear.
- R3: Raw bit 0 is 1 exactly while the transmit level is at or below the transmit threshold register. Clear writes do not affect it.
- R4: Raw bit 4 is 1 exactly while the receive level is strictly above the receive threshold register. Clear writes do not affect it.
- R5: On the clock edge, a push while the transmit level equals DEPTH sets raw bit 1. A pop while the receive level is zero sets raw bit 2. A delivered frame while the receive level equals DEPTH sets raw bit 3. Each becomes visible after that edge.
- R6: A sticky bit stays set on every edge without a matching clear write.
- R7: A clear write takes effect on the edge. Bit 0 clears all three sticky bits. Bit 1 clears rx-underflow, bit 2 clears rx-overflow and bit 3 clears tx-overflow. A clear bit that is not written leaves the other sources alone.
- R8: If a set event and a clear of the same bit fall on the same edge, the bit ends up set.
- R9: The masked vector is the raw vector ANDed with the mask register, which is loaded on the edge of a mask write. The interrupt line is the OR of the masked bits.
- R10: In the DMA enable register, bit 0 enables receive and bit 1 enables transmit. The transmit request equals the transmit enable ANDed with raw bit 0. The receive request equals the receive enable ANDed with raw bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Serial engine busy |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_push_i | input | 1 | Write into transmit FIFO |
| rx_pop_i | input | 1 | Read from receive FIFO |
| rx_frame_i | input | 1 | Engine delivers a received frame |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 5 | Mask write data |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 4 | Clear write data |
| dma_we_i | input | 1 | DMA enable register write strobe |
| dma_wdata_i | input | 2 | DMA enable write data |
| txthr_we_i | input | 1 | Transmit threshold write strobe |
| rxthr_we_i | input | 1 | Receive threshold write strobe |
| thr_wdata_i | input | LVL_W | Threshold write data |
| status_o | output | 5 | Status word |
| raw_irq_o | output | 5 | Raw interrupt vector |
| masked_irq_o | output | 5 | Masked interrupt vector |
| irq_o | output | 1 | Combined interrupt line |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The levels are stepped across each threshold by one, so an off-by-one between "at or below" and "above" shows up. They are also held at zero and DEPTH, which separates the full and empty status bits from the threshold sources. Error strobes are applied both at the full or empty boundary and one step away from it, which tells a correct trigger condition from a loose one. Each clear bit is written alone against all three latched sources, so a swapped clear order shows up. A set and a clear on the same edge shows which one wins. Mask and DMA patterns with single bits set tell the gating of each output bit apart.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NIRQ = 5;
  localparam int NCLR = 4;
  localparam int NSTICKY = 3;

  // status bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;

  // interrupt bit positions
  localparam int IRQ_TXLOW = 0;
  localparam int IRQ_TXOVF = 1;
  localparam int IRQ_RXUNF = 2;
  localparam int IRQ_RXOVF = 3;
  localparam int IRQ_RXHI  = 4;

  // sticky slot order inside the sticky bank
  localparam int SK_TXOVF = 0;
  localparam int SK_RXUNF = 1;
  localparam int SK_RXOVF = 2;

  // map the clear-register layout onto sticky slots (R7)
  function automatic logic [NSTICKY-1:0] clr_decode(input logic [NCLR-1:0] c);
    logic [NSTICKY-1:0] r;
    r           = '0;
    r[SK_TXOVF] = c[0] | c[3];
    r[SK_RXUNF] = c[0] | c[1];
    r[SK_RXOVF] = c[0] | c[2];
    return r;
  endfunction
endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/spi_lvl_flags.sv
module spi_lvl_flags #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             tx_low,
  output logic             rx_high
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  function automatic logic at_or_below(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic strictly_above(input logic [LVL_W-1:0] lvl,
                                          input logic [LVL_W-1:0] thr);
    return lvl > thr;
  endfunction

  always_comb begin
    tx_full  = (tx_level == FULL_LVL);
    tx_empty = (tx_level == '0);
    rx_full  = (rx_level == FULL_LVL);
    rx_empty = (rx_level == '0);
    tx_low   = at_or_below(tx_level, tx_thr);
    rx_high  = strictly_above(rx_level, rx_thr);
  end
endmodule

// File: rtl/spi_sticky_bank.sv
module spi_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= 1'b0;
      else if (set_ev[i]) q[i] <= 1'b1;   // set beats clear
      else if (clr_ev[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             tx_push_i,
  input  logic             rx_pop_i,
  input  logic             rx_frame_i,
  input  logic             mask_we_i,
  input  logic [4:0]       mask_wdata_i,
  input  logic             clr_we_i,
  input  logic [3:0]       clr_wdata_i,
  input  logic             dma_we_i,
  input  logic [1:0]       dma_wdata_i,
  input  logic             txthr_we_i,
  input  logic             rxthr_we_i,
  input  logic [LVL_W-1:0] thr_wdata_i,
  output logic [4:0]       status_o,
  output logic [4:0]       raw_irq_o,
  output logic [4:0]       masked_irq_o,
  output logic             irq_o,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o
);
  logic [NIRQ-1:0]    mask_q;
  logic [1:0]         dma_en_q;
  logic [LVL_W-1:0]   tx_thr_q, rx_thr_q;
  logic               tx_full, tx_empty, rx_full, rx_empty, tx_low, rx_high;
  logic [NSTICKY-1:0] sticky_set, sticky_clr, sticky_q;

  spi_cfg_reg #(.W(NIRQ))  u_mask  (.clk(clk), .rst_n(rst_n), .we(mask_we_i),
                                    .d(mask_wdata_i), .q(mask_q));
  spi_cfg_reg #(.W(2))     u_dma   (.clk(clk), .rst_n(rst_n), .we(dma_we_i),
                                    .d(dma_wdata_i), .q(dma_en_q));
  spi_cfg_reg #(.W(LVL_W)) u_txthr (.clk(clk), .rst_n(rst_n), .we(txthr_we_i),
                                    .d(thr_wdata_i), .q(tx_thr_q));
  spi_cfg_reg #(.W(LVL_W)) u_rxthr (.clk(clk), .rst_n(rst_n), .we(rxthr_we_i),
                                    .d(thr_wdata_i), .q(rx_thr_q));

  spi_lvl_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
    .tx_level(tx_level_i), .rx_level(rx_level_i),
    .tx_thr(tx_thr_q), .rx_thr(rx_thr_q),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_low(tx_low), .rx_high(rx_high)
  );

  // named error events
  logic ev_tx_ovf, ev_rx_unf, ev_rx_ovf;
  assign ev_tx_ovf = tx_push_i  & tx_full;
  assign ev_rx_unf = rx_pop_i   & rx_empty;
  assign ev_rx_ovf = rx_frame_i & rx_full;

  always_comb begin
    sticky_set           = '0;
    sticky_set[SK_TXOVF] = ev_tx_ovf;
    sticky_set[SK_RXUNF] = ev_rx_unf;
    sticky_set[SK_RXOVF] = ev_rx_ovf;
    sticky_clr           = clr_we_i ? clr_decode(clr_wdata_i) : '0;
  end

  spi_sticky_bank #(.N(NSTICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_ev(sticky_set), .clr_ev(sticky_clr), .q(sticky_q)
  );

  always_comb begin
    status_o             = '0;
    status_o[ST_BUSY]    = busy_i;
    status_o[ST_TXFULL]  = tx_full;
    status_o[ST_TXEMPTY] = tx_empty;
    status_o[ST_RXEMPTY] = rx_empty;
    status_o[ST_RXFULL]  = rx_full;

    raw_irq_o            = '0;
    raw_irq_o[IRQ_TXLOW] = tx_low;
    raw_irq_o[IRQ_TXOVF] = sticky_q[SK_TXOVF];
    raw_irq_o[IRQ_RXUNF] = sticky_q[SK_RXUNF];
    raw_irq_o[IRQ_RXOVF] = sticky_q[SK_RXOVF];
    raw_irq_o[IRQ_RXHI]  = rx_high;
  end

  assign masked_irq_o = raw_irq_o & mask_q;
  assign irq_o        = |masked_irq_o;
  assign tx_dma_req_o = dma_en_q[1] & tx_low;
  assign rx_dma_req_o = dma_en_q[0] & rx_high;
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_push_i,
  input logic             rx_pop_i,
  input logic             rx_frame_i,
  input logic             mask_we_i,
  input logic [4:0]       mask_wdata_i,
  input logic             clr_we_i,
  input logic [3:0]       clr_wdata_i,
  input logic [LVL_W-1:0] tx_level_i,
  input logic [4:0]       status_o,
  input logic [4:0]       raw_irq_o,
  input logic [4:0]       masked_irq_o,
  input logic             irq_o,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[1] && status_o[2]) || (tx_level_i == '0 && status_o[1] == 1'b0)); // R1
  AST_TXOVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_i && status_o[1]) |=> raw_irq_o[1]); // R5
  AST_RXUNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_i && status_o[3]) |=> raw_irq_o[2]); // R5
  AST_RXOVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_i && status_o[4]) |=> raw_irq_o[3]); // R5
  AST_TXOVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq_o[1] && !(clr_we_i && (clr_wdata_i[0] || clr_wdata_i[3]))) |=> raw_irq_o[1]); // R6
  AST_TXOVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_wdata_i[3] && !(tx_push_i && status_o[1])) |=> !raw_irq_o[1]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_i && status_o[1] && clr_we_i && clr_wdata_i[0]) |=> raw_irq_o[1]); // R8
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_irq_o & ~raw_irq_o) == 5'b0); // R9
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (masked_irq_o != 5'b0)); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> masked_irq_o == (raw_irq_o & $past(mask_wdata_i))); // R9
  AST_TXDMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req_o |-> raw_irq_o[0]); // R10
  AST_RXDMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req_o |-> raw_irq_o[4]); // R10
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_push_i(tx_push_i), .rx_pop_i(rx_pop_i),
  .rx_frame_i(rx_frame_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
  .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i), .tx_level_i(tx_level_i),
  .status_o(status_o), .raw_irq_o(raw_irq_o), .masked_irq_o(masked_irq_o),
  .irq_o(irq_o), .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o)
);

// File: tb/test_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module test_spi_fifo_irq_unit;
  localparam int D = 32;
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic busy = 0, push = 0, pop = 0, frame = 0;
  logic [LW-1:0] txl = '0, rxl = '0, thr_d = '0;
  logic mask_we = 0, clr_we = 0, dma_we = 0, txthr_we = 0, rxthr_we = 0;
  logic [4:0] mask_d = '0;
  logic [3:0] clr_d = '0;
  logic [1:0] dma_d = '0;
  logic [4:0] st, raw, msk;
  logic irq, txd, rxd;

  spi_fifo_irq_unit #(.DEPTH(D)) i_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .tx_level_i(txl), .rx_level_i(rxl),
    .tx_push_i(push), .rx_pop_i(pop), .rx_frame_i(frame),
    .mask_we_i(mask_we), .mask_wdata_i(mask_d), .clr_we_i(clr_we), .clr_wdata_i(clr_d),
    .dma_we_i(dma_we), .dma_wdata_i(dma_d), .txthr_we_i(txthr_we), .rxthr_we_i(rxthr_we),
    .thr_wdata_i(thr_d), .status_o(st), .raw_irq_o(raw), .masked_irq_o(msk),
    .irq_o(irq), .tx_dma_req_o(txd), .rx_dma_req_o(rxd)
  );

  typedef struct {
    logic [4:0] st, raw, msk;
    logic irq, txd, rxd;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state, kept from the requirements
  bit m_txo = 0, m_rxu = 0, m_rxo = 0;
  logic [4:0] m_mask = '0;
  logic [1:0] m_dma = '0;
  int m_txthr = 0, m_rxthr = 0;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // driver: applies one edge, pushes what the outputs must be after it
  task automatic cyc(string tag);
    exp_t e;
    bit sx, su, so;
    sx = push  && (int'(txl) == D);
    su = pop   && (rxl == 0);
    so = frame && (int'(rxl) == D);
    if (clr_we) begin
      if (clr_d[0] || clr_d[3]) m_txo = 0;
      if (clr_d[0] || clr_d[1]) m_rxu = 0;
      if (clr_d[0] || clr_d[2]) m_rxo = 0;
    end
    if (sx) m_txo = 1;
    if (su) m_rxu = 1;
    if (so) m_rxo = 1;
    if (mask_we)  m_mask  = mask_d;
    if (dma_we)   m_dma   = dma_d;
    if (txthr_we) m_txthr = int'(thr_d);
    if (rxthr_we) m_rxthr = int'(thr_d);
    e.st  = {int'(rxl) == D, rxl == 0, txl == 0, int'(txl) == D, busy};
    e.raw = {int'(rxl) > m_rxthr, m_rxo, m_rxu, m_txo, int'(txl) <= m_txthr};
    e.msk = e.raw & m_mask;
    e.irq = |e.msk;
    e.txd = m_dma[1] && e.raw[0];
    e.rxd = m_dma[0] && e.raw[4];
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    push = 0; pop = 0; frame = 0; mask_we = 0; clr_we = 0; dma_we = 0;
    txthr_we = 0; rxthr_we = 0;
  endtask

  // monitor: compares a quarter period after each edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (st !== e.st || raw !== e.raw || msk !== e.msk || irq !== e.irq ||
            txd !== e.txd || rxd !== e.rxd) begin
          n_bad++;
          $display("FAIL %s: st=%b raw=%b msk=%b irq=%b dma=%b%b expected st=%b raw=%b msk=%b irq=%b dma=%b%b",
                   e.tag, st, raw, msk, irq, txd, rxd,
                   e.st, e.raw, e.msk, e.irq, e.txd, e.rxd);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R2 reset values, R1 status in reset
    n_chk++;
    if (st !== 5'b01100 || raw !== 5'b00001 || msk !== 5'b0 || irq !== 1'b0 || txd || rxd) begin
      n_bad++;
      $display("FAIL R2 reset: st=%b raw=%b msk=%b expected st=01100 raw=00001 msk=00000", st, raw, msk);
    end
    rst_n = 1;
    cyc("R2 idle after reset");

    // R1 status layout
    busy = 1; txl = LW'(D); cyc("R1 busy and tx full");
    busy = 0; txl = 5; rxl = LW'(D); cyc("R1 rx full");
    rxl = 3; cyc("R1 mid levels");

    // R3 transmit threshold boundary
    thr_d = 4; txthr_we = 1; cyc("R3 threshold load");
    txl = 4; cyc("R3 at threshold");
    txl = 5; cyc("R3 above threshold");
    // R4 receive threshold boundary
    thr_d = 8; rxthr_we = 1; rxl = 8; cyc("R4 at threshold");
    rxl = 9; cyc("R4 above threshold");
    rxl = 3;

    // R5 error events, near and at the boundary
    txl = LW'(D - 1); push = 1; cyc("R5 push not full");
    txl = LW'(D);     push = 1; cyc("R5 push when full");
    rxl = 1; pop = 1; cyc("R5 pop not empty");
    rxl = 0; pop = 1; cyc("R5 pop when empty");
    rxl = LW'(D - 1); frame = 1; cyc("R5 frame not full");
    rxl = LW'(D);     frame = 1; cyc("R5 frame when full");
    rxl = 2; txl = 6;
    cyc("R6 hold one");
    cyc("R6 hold two");

    // R7 clear encoding, one bit at a time
    clr_we = 1; clr_d = 4'b1000; cyc("R7 clear tx overflow only");
    clr_we = 1; clr_d = 4'b0010; cyc("R7 clear rx underflow only");
    clr_we = 1; clr_d = 4'b0100; cyc("R7 clear rx overflow only");
    txl = LW'(D); push = 1; rxl = 0; pop = 1; cyc("R5 set two again");
    txl = 2; rxl = 20;
    clr_we = 1; clr_d = 4'b0001; cyc("R7 clear all, level bits unaffected");

    // R8 set and clear on one edge
    txl = LW'(D); push = 1; clr_we = 1; clr_d = 4'b1000; cyc("R8 set beats clear");
    txl = 6; clr_we = 1; clr_d = 4'b1000; cyc("R7 clear afterwards");

    // R9 mask
    txl = 0; rxl = 20;
    mask_we = 1; mask_d = 5'b10000; cyc("R9 mask rx high");
    mask_we = 1; mask_d = 5'b00001; cyc("R9 mask tx low");
    mask_we = 1; mask_d = 5'b00110; cyc("R9 mask errors, none pending");
    rxl = 0; pop = 1; cyc("R9 masked error raises line");
    mask_we = 1; mask_d = 5'b0; cyc("R9 mask cleared");

    // R10 DMA enables
    dma_we = 1; dma_d = 2'b10; cyc("R10 tx dma only");
    dma_we = 1; dma_d = 2'b01; rxl = 9; cyc("R10 rx dma only");
    dma_we = 1; dma_d = 2'b11; txl = 5; rxl = 8; cyc("R10 both enabled, both off");
    txl = 4; rxl = 9; cyc("R10 both enabled, both on");

    repeat (3) @(negedge clk);
    report();
  end
endmodule